// File: doc/BRIEF.md
# Serial OSD Command Packet Decoder

This block sits behind a three-wire serial link that a host controller uses to fill the character and control memory of an on-screen display. The link has an active-low frame enable, a serial clock and a serial data line. The block samples all three with the local clock and assembles bytes MSB first. It then sorts each byte into one of three kinds: row address, column address or data. From that byte stream it issues one write per data byte. Each write carries a row, a column, a plane select (character-code plane or attribute plane) and the byte itself.

Three packet formats can be mixed within one frame. A host can send full row/column/data triples. It can send one row followed by column/data pairs. It can also send one row and one column followed by a run of data bytes, for which the decoder advances the address itself. The streaming run is a one-way door: once it starts, every later byte in the frame is data. Raising the frame enable ends the frame at once and returns the decoder to waiting for a row byte.

The state machine has five states:
- `ST_IDLE` waits for a row byte.
- `ST_COL` holds a row and waits for a column byte or a replacement row.
- `ST_DATA` waits for the single data byte of a triple or pair.
- `ST_NEXT` follows that data byte and accepts either a row or a column.
- `ST_STREAM` treats every byte as auto-addressed data.

The transitions are:
- Row byte: `ST_IDLE`, `ST_COL` or `ST_NEXT` go to `ST_COL`.
- Per-byte column: `ST_COL` or `ST_NEXT` go to `ST_DATA`.
- Streaming column: `ST_COL` or `ST_NEXT` go to `ST_STREAM`.
- Data byte: `ST_DATA` goes to `ST_NEXT`.
- Data byte: `ST_STREAM` stays in `ST_STREAM`.
- Frame end: any state goes to `ST_IDLE`.
- A column-coded byte in `ST_IDLE` is dropped and the state does not change.

Top module: `osd_pkt_decoder`

## Requirements
- R1: While and after reset, wr_stb is 0 and the decoder waits for a row byte.
- R2: Bits are taken only on rising serial-clock edges while the frame enable is low. A byte is complete after 8 such bits, first bit as bit 7. Clock edges while the frame enable is high add nothing.
- R3: A byte with bit 7 = 1 is a row byte when a row or column is expected. Bits 3..0 give the row, and bit 6 gives the plane (0 = character-code plane, 1 = attribute plane). Bits 5..4 are ignored.
- R4: A byte with bit 7 = 0 is a column byte when a column is accepted, and bits 4..0 give the column. Bit 6 = 0 selects per-byte mode (next byte is one data byte) and bit 6 = 1 selects streaming.
- R5: Triple format: row, column (bit 6 = 0), data writes the data byte at that row, column and plane, whatever the data byte's top bits are.
- R6: Pair format: after one row, repeated column/data pairs each write at the latest column and the same row and plane.
- R7: In streaming, each data byte is written at the current address and the column then advances by one. Column 31 wraps to 0, and in that same step the row advances by one, wrapping from 15 to 0.
- R8: Once streaming begins, every further byte of the frame is data, including bytes whose bit 7 is 1.
- R9: A byte with bit 7 = 0 arriving when a row is expected is discarded and writes nothing.
- R10: Frame enable going high discards any partial byte and returns the decoder to waiting for a row byte.
- R11: Each data byte gives exactly one single-cycle wr_stb. wr_row, wr_col, wr_plane and wr_data change only together with a strobe.
- R12: Within one frame, the decoder may go from the triple format to the pair or streaming format, and from the pair format back to the triple format.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock that samples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Serial frame enable, active low |
| ser_clk | input | 1 | Serial bit clock, data taken on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_row | output | ROW_W | Row of the write |
| wr_col | output | COL_W | Column of the write |
| wr_plane | output | 1 | 0 = character-code plane, 1 = attribute plane |
| wr_data | output | 8 | Data byte to write |

## Verification
The bench builds the decoder with its defaults: two synchroniser stages, a 4-bit row and a 5-bit column. With these widths, a 34-byte stream that starts at row 15, column 30 crosses both the column wrap and the row wrap in one frame. With the 2-stage synchroniser, a serial half-period of four local clocks still passes every bit cleanly. Expected writes are pushed into a queue by the driver tasks. They are matched in order against each strobe, so format switches, dropped bytes and aborted partial bytes all show up as missing, extra or misaddressed writes.

// File: rtl/osd_pkt_pkg.sv
package osd_pkt_pkg;

    // Decoder states
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,   // expecting a row byte
        ST_COL    = 3'd1,   // row held, expecting column (or a new row)
        ST_DATA   = 3'd2,   // expecting the single data byte of a triple/pair
        ST_NEXT   = 3'd3,   // after per-byte data: row or column accepted
        ST_STREAM = 3'd4    // every byte is data, address advances itself
    } dec_state_t;

    localparam int BYTE_W    = 8;
    localparam int KIND_BIT  = 7;   // 1 = row byte, 0 = column byte
    localparam int PLANE_BIT = 6;   // row byte: plane select
    localparam int MODE_BIT  = 6;   // column byte: 1 = streaming

    function automatic logic is_row_byte(input logic [BYTE_W-1:0] b);
        return b[KIND_BIT];
    endfunction

    function automatic logic is_stream_col(input logic [BYTE_W-1:0] b);
        return b[MODE_BIT];
    endfunction

endpackage

// File: rtl/osd_link_sync.sv
module osd_link_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic ser_clk,
    input  logic ser_dat,
    output logic frame_off,
    output logic bit_stb,
    output logic bit_val
);

    localparam int NSIG = 3;   // frame, clock, data
    localparam logic [NSIG-1:0] IDLE_LVL = 3'b100;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] chain [STAGES];
    logic            clk_prev;

    assign raw = {frame_n, ser_clk, ser_dat};

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= IDLE_LVL;
                    else        chain[s] <= raw;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= IDLE_LVL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_prev <= 1'b0;
        else        clk_prev <= chain[STAGES-1][1];
    end

    assign frame_off = chain[STAGES-1][2];
    assign bit_stb   = chain[STAGES-1][1] & ~clk_prev & ~frame_off;
    assign bit_val   = chain[STAGES-1][0];

endmodule

// File: rtl/osd_byte_shifter.sv
module osd_byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_off,
    input  logic         bit_stb,
    input  logic         bit_val,
    output logic         byte_vld,
    output logic [W-1:0] byte_q
);

    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [W-1:0]     shreg;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            cnt      <= '0;
            byte_vld <= 1'b0;
            byte_q   <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (frame_off) begin
                cnt <= '0;
            end else if (bit_stb) begin
                shreg <= {shreg[W-2:0], bit_val};
                if (cnt == LAST) begin
                    cnt      <= '0;
                    byte_vld <= 1'b1;
                    byte_q   <= {shreg[W-2:0], bit_val};
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/osd_pkt_fsm.sv
module osd_pkt_fsm
    import osd_pkt_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int COL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_off,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    output dec_state_t        state,
    output logic              wr_stb,
    output logic [ROW_W-1:0]  wr_row,
    output logic [COL_W-1:0]  wr_col,
    output logic              wr_plane,
    output logic [BYTE_W-1:0] wr_data
);

    dec_state_t       st_q, st_nxt;
    logic             take_row, take_col, emit, step;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             plane_q;

    // next state and actions
    always_comb begin
        st_nxt   = st_q;
        take_row = 1'b0;
        take_col = 1'b0;
        emit     = 1'b0;
        step     = 1'b0;
        if (frame_off) begin
            st_nxt = ST_IDLE;
        end else if (byte_vld) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (is_row_byte(byte_in)) begin
                        take_row = 1'b1;
                        st_nxt   = ST_COL;
                    end
                end
                ST_COL, ST_NEXT: begin
                    if (is_row_byte(byte_in)) begin
                        take_row = 1'b1;
                        st_nxt   = ST_COL;
                    end else begin
                        take_col = 1'b1;
                        st_nxt   = is_stream_col(byte_in) ? ST_STREAM : ST_DATA;
                    end
                end
                ST_DATA: begin
                    emit   = 1'b1;
                    st_nxt = ST_NEXT;
                end
                ST_STREAM: begin
                    emit = 1'b1;
                    step = 1'b1;
                end
                default: st_nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    // address registers and write outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q    <= '0;
            col_q    <= '0;
            plane_q  <= 1'b0;
            wr_stb   <= 1'b0;
            wr_row   <= '0;
            wr_col   <= '0;
            wr_plane <= 1'b0;
            wr_data  <= '0;
        end else begin
            wr_stb <= emit;
            if (take_row) begin
                row_q   <= byte_in[ROW_W-1:0];
                plane_q <= byte_in[PLANE_BIT];
            end
            if (take_col) begin
                col_q <= byte_in[COL_W-1:0];
            end
            if (emit) begin
                wr_row   <= row_q;
                wr_col   <= col_q;
                wr_plane <= plane_q;
                wr_data  <= byte_in;
            end
            if (step) begin
                col_q <= col_q + 1'b1;
                if (&col_q) row_q <= row_q + 1'b1;
            end
        end
    end

    assign state = st_q;

endmodule

// File: rtl/osd_pkt_decoder.sv
module osd_pkt_decoder
    import osd_pkt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ROW_W       = 4,
    parameter int COL_W       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    output logic              wr_stb,
    output logic [ROW_W-1:0]  wr_row,
    output logic [COL_W-1:0]  wr_col,
    output logic              wr_plane,
    output logic [BYTE_W-1:0] wr_data
);

    logic              frame_off;
    logic              bit_stb;
    logic              bit_val;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_q;
    dec_state_t        fsm_state;

    osd_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat),
        .frame_off (frame_off),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val)
    );

    osd_byte_shifter #(.W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_off (frame_off),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .byte_vld  (byte_vld),
        .byte_q    (byte_q)
    );

    osd_pkt_fsm #(.ROW_W(ROW_W), .COL_W(COL_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_off (frame_off),
        .byte_vld  (byte_vld),
        .byte_in   (byte_q),
        .state     (fsm_state),
        .wr_stb    (wr_stb),
        .wr_row    (wr_row),
        .wr_col    (wr_col),
        .wr_plane  (wr_plane),
        .wr_data   (wr_data)
    );

endmodule

// File: rtl/osd_pkt_decoder_chk.sv
module osd_pkt_decoder_chk
    import osd_pkt_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int COL_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic [ROW_W-1:0]  wr_row,
    input logic [COL_W-1:0]  wr_col,
    input logic              wr_plane,
    input logic [BYTE_W-1:0] wr_data,
    input logic              frame_off,
    input logic              byte_vld,
    input logic [BYTE_W-1:0] byte_q,
    input dec_state_t        state
);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (wr_stb == 1'b0 && state == ST_IDLE);
        end
    end

    // R11
    stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R11
    hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |-> $stable({wr_row, wr_col, wr_plane, wr_data}));

    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_off |=> state == ST_IDLE);

    // R8
    stream_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && !frame_off) |=> state == ST_STREAM);

    // R7
    stream_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && byte_vld && !frame_off) |=> wr_stb);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |=> !wr_stb);

    // R5
    data_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && byte_vld && !frame_off) |=> (wr_stb && state == ST_NEXT));

    // R4
    col_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_COL || state == ST_NEXT) && byte_vld && !frame_off && !byte_q[7])
        |=> state == ($past(byte_q[6]) ? ST_STREAM : ST_DATA));

    // R3
    row_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_DATA && state != ST_STREAM && byte_vld && !frame_off && byte_q[7])
        |=> state == ST_COL);

endmodule

bind osd_pkt_decoder osd_pkt_decoder_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .wr_row    (wr_row),
    .wr_col    (wr_col),
    .wr_plane  (wr_plane),
    .wr_data   (wr_data),
    .frame_off (frame_off),
    .byte_vld  (byte_vld),
    .byte_q    (byte_q),
    .state     (fsm_state)
);

// File: tb/osd_pkt_decoder_test.sv
`timescale 1ns/1ps
module osd_pkt_decoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_n = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       wr_stb;
    logic [3:0] wr_row;
    logic [4:0] wr_col;
    logic       wr_plane;
    logic [7:0] wr_data;

    int    errors = 0;
    int    checks = 0;
    bit    done   = 1'b0;
    string cur_tag = "R1";

    typedef struct packed {
        logic [3:0] row;
        logic [4:0] col;
        logic       plane;
        logic [7:0] data;
    } wr_item_t;

    wr_item_t exp_q[$];
    string    tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    osd_pkt_decoder uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .ser_clk  (ser_clk),
        .ser_dat  (ser_dat),
        .wr_stb   (wr_stb),
        .wr_row   (wr_row),
        .wr_col   (wr_col),
        .wr_plane (wr_plane),
        .wr_data  (wr_data)
    );

    function automatic logic [7:0] row_b(input logic plane, input logic [3:0] r);
        return {1'b1, plane, 2'b00, r};
    endfunction

    function automatic logic [7:0] col_b(input logic stream, input logic [4:0] c);
        return {1'b0, stream, 1'b0, c};
    endfunction

    task automatic expect_wr(input logic [3:0] r, input logic [4:0] c,
                             input logic p, input logic [7:0] d, input string tag);
        wr_item_t it;
        it.row = r; it.col = c; it.plane = p; it.data = d;
        exp_q.push_back(it);
        tag_q.push_back(tag);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            ser_dat = b[i];
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic frame_begin();
        frame_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic frame_end();
        repeat (4) @(negedge clk);
        frame_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        repeat (20) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d expected writes missing (expected 0 left)", tag, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    // monitor / scoreboard
    logic prev_stb = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (wr_stb) begin
                checks++;
                if (prev_stb) begin
                    errors++;
                    $display("FAIL R11: strobe wider than one cycle (actual 2+ cycles, expected 1)");
                end
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL %s: unexpected write row=%0d col=%0d plane=%0d data=%h (expected none)",
                             cur_tag, wr_row, wr_col, wr_plane, wr_data);
                end else begin
                    wr_item_t e;
                    string    t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (wr_row != e.row || wr_col != e.col || wr_plane != e.plane || wr_data != e.data) begin
                        errors++;
                        $display("FAIL %s: write actual r=%0d c=%0d p=%0d d=%h expected r=%0d c=%0d p=%0d d=%h",
                                 t, wr_row, wr_col, wr_plane, wr_data, e.row, e.col, e.plane, e.data);
                    end
                end
            end
            prev_stb = wr_stb;
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete (expected finish before limit)");
        finish_run();
    end

    initial begin
        logic [3:0] er;
        logic [4:0] ec;

        repeat (5) @(negedge clk);
        // R1: reset state at the ports
        checks++;
        if (wr_stb !== 1'b0) begin
            errors++;
            $display("FAIL R1: wr_stb during reset actual=%b expected=0", wr_stb);
        end
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        checks++;
        if (wr_stb !== 1'b0) begin
            errors++;
            $display("FAIL R1: wr_stb after reset actual=%b expected=0", wr_stb);
        end

        // R2: clock edges with frame enable high are ignored
        cur_tag = "R2";
        send_byte(8'hFF);
        send_bits(8'h80, 3);
        drain("R2");

        // R5 / R3: triple format, data with top bits set, both planes
        cur_tag = "R5";
        frame_begin();
        send_byte(row_b(1'b0, 4'd3)); send_byte(col_b(1'b0, 5'd5));
        expect_wr(4'd3, 5'd5, 1'b0, 8'h41, "R5"); send_byte(8'h41);
        send_byte(row_b(1'b1, 4'd9)); send_byte(col_b(1'b0, 5'd17));
        expect_wr(4'd9, 5'd17, 1'b1, 8'h8C, "R5"); send_byte(8'h8C);
        send_byte(8'hB7); send_byte(col_b(1'b0, 5'd31));   // R3: bits 5..4 ignored
        expect_wr(4'd7, 5'd31, 1'b0, 8'hC0, "R3"); send_byte(8'hC0);
        frame_end();
        drain("R5");

        // R6: pair format
        cur_tag = "R6";
        frame_begin();
        send_byte(row_b(1'b1, 4'd2));
        send_byte(col_b(1'b0, 5'd1));  expect_wr(4'd2, 5'd1, 1'b1, 8'h10, "R6"); send_byte(8'h10);
        send_byte(col_b(1'b0, 5'd22)); expect_wr(4'd2, 5'd22, 1'b1, 8'hFF, "R6"); send_byte(8'hFF);
        send_byte(col_b(1'b0, 5'd0));  expect_wr(4'd2, 5'd0, 1'b1, 8'h00, "R6"); send_byte(8'h00);
        frame_end();
        drain("R6");

        // R12 / R7 / R8: pair -> triple -> streaming across both wraps
        cur_tag = "R12";
        frame_begin();
        send_byte(row_b(1'b0, 4'd4));
        send_byte(col_b(1'b0, 5'd2)); expect_wr(4'd4, 5'd2, 1'b0, 8'h11, "R12"); send_byte(8'h11);
        send_byte(row_b(1'b1, 4'd5)); send_byte(col_b(1'b0, 5'd7));
        expect_wr(4'd5, 5'd7, 1'b1, 8'h33, "R12"); send_byte(8'h33);
        send_byte(row_b(1'b0, 4'd15)); send_byte(col_b(1'b1, 5'd30));
        cur_tag = "R7";
        er = 4'd15; ec = 5'd30;
        for (int k = 0; k < 34; k++) begin
            logic [7:0] d;
            d = (k % 3 == 0) ? (8'h9A ^ 8'(k)) : (k % 3 == 1) ? col_b(1'b1, 5'(k)) : 8'(k * 7);
            expect_wr(er, ec, 1'b0, d, (k < 3) ? "R7" : "R8");
            send_byte(d);
            if (ec == 5'd31) er = er + 1'b1;
            ec = ec + 1'b1;
        end
        frame_end();
        drain("R7");

        // R9: column-coded bytes while a row is expected are dropped
        cur_tag = "R9";
        frame_begin();
        send_byte(8'h05); send_byte(8'h47);
        send_byte(row_b(1'b0, 4'd6)); send_byte(col_b(1'b0, 5'd8));
        expect_wr(4'd6, 5'd8, 1'b0, 8'h5A, "R9"); send_byte(8'h5A);
        frame_end();
        drain("R9");

        // R10: partial byte discarded on frame end
        cur_tag = "R10";
        frame_begin();
        send_bits(8'h83, 5);
        frame_end();
        frame_begin();
        send_byte(row_b(1'b1, 4'd1)); send_byte(col_b(1'b0, 5'd4));
        expect_wr(4'd1, 5'd4, 1'b1, 8'h77, "R10"); send_byte(8'h77);
        frame_end();
        drain("R10");

        // R10: mid-packet abort returns to row expectation
        frame_begin();
        send_byte(row_b(1'b0, 4'd1)); send_byte(col_b(1'b0, 5'd4));
        frame_end();
        frame_begin();
        send_byte(8'h33);                       // would be data if state persisted
        send_byte(row_b(1'b0, 4'd8)); send_byte(col_b(1'b0, 5'd9));
        expect_wr(4'd8, 5'd9, 1'b0, 8'h12, "R10"); send_byte(8'h12);
        frame_end();
        drain("R10");

        // R10 / R8: streaming ends with the frame
        frame_begin();
        send_byte(row_b(1'b0, 4'd0)); send_byte(col_b(1'b1, 5'd0));
        expect_wr(4'd0, 5'd0, 1'b0, 8'hA5, "R8"); send_byte(8'hA5);
        frame_end();
        frame_begin();
        send_byte(row_b(1'b1, 4'd5)); send_byte(col_b(1'b0, 5'd3));
        expect_wr(4'd5, 5'd3, 1'b1, 8'h66, "R10"); send_byte(8'h66);
        frame_end();
        drain("R10");

        finish_run();
    end

endmodule